// File: doc/BRIEF.md
# MDIO Management Read Master

This block runs read transactions against a PHY over the two-wire management interface, with a clock line (MDC) and a bidirectional data line (MDIO). The host starts a read with a one-cycle command strobe. The strobe carries a 5-bit PHY address, a 5-bit register address (any of registers 0 to 31) and an interrupt-enable flag. The master then generates MDC by dividing the system clock. On MDIO it drives a run of preamble ones, the start pattern, the read opcode and both addresses, and then releases the line so the PHY can reply.

The PHY replies with one leading bit and then sixteen data bits. The master drops the leading bit and shifts the sixteen data bits into its result register. It then raises a ready flag and, if the command asked for it, an interrupt flag. Both flags stay set until the host issues the next command. While a read is in flight the master is busy, and any command it receives during that time is dropped.

The chip-level pad instantiates the tri-state buffer from `mdio_o` and `mdio_oe`. Its input side feeds `mdio_i`.

Top module: `mdio_rd_master`

## Requirements
- R1: While reset is active and after it is released, `rdy`, `irq`, `busy`, `mdc` and `mdio_oe` are all 0 until a command is accepted.
- R2: Each accepted read starts with 32 bit periods in which `mdio_oe`=1 and `mdio_o`=1 at every MDC rising edge.
- R3: The preamble is followed by 14 driven bits: start `0,1`, opcode `1,0`, the 5-bit PHY address MSB first, and the 5-bit register address MSB first. These are frame bits 32 to 45, counted from 0 at the first MDC rising edge.
- R4: At the rising edges of frame bits 46 to 63, `mdio_oe` is 0. `mdio_o` and `mdio_oe` change only in the system cycle in which MDC falls, or in the cycle that accepts a command.
- R5: The bit that the PHY presents at frame bit 47 is discarded. The bits sampled at the MDC rising edges of frame bits 48 to 63 become `rd_data[15]` down to `rd_data[0]`.
- R6: Each read has exactly 64 MDC rising edges. In the system cycle in which MDC falls after frame bit 63, `busy` drops and `rdy` rises.
- R7: At completion `irq` equals the interrupt-enable flag of the command. It holds that value until the next accepted command clears it.
- R8: A command is accepted only when `busy`=0. Accepting it clears `rdy` and `irq` and sets `busy` in the next cycle. A command strobed while `busy`=1 changes neither the frame nor the result, and it starts no further read.
- R9: MDC has a period of 2*HALF_DIV system cycles during a read and is held at 0 while idle.
- R10: All 32 PHY addresses and all 32 register addresses are framed and returned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | One-cycle read command strobe |
| cmd_phy | input | AW | PHY address of the command |
| cmd_reg | input | AW | Register address of the command (0 to 31) |
| cmd_ie | input | 1 | Interrupt enable for this command |
| busy | output | 1 | Read in progress, commands ignored |
| rdy | output | 1 | Result valid, read complete |
| irq | output | 1 | Completion interrupt (level) |
| rd_data | output | DW | Received register value |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
If the bit counter in the state machine is off by one in any phase, the frame grows or shrinks. The bench sees this as a wrong rising-edge count, a shifted header bit or a byte-slipped result at the end of that same read, within about 64 MDC periods. A shift register that keeps the discarded reply bit shows up as wrong data whenever the PHY model drives that bit to 1. A stale command latch shows up when a command strobed during a read leaves its trace on the header or the interrupt flag. The sweep covers every PHY address and every register address, so a swapped or mis-ordered address bit fails within the first few reads.

// File: rtl/mdio_rd_pkg.sv
package mdio_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_TA,
    ST_DATA
  } mrd_state_e;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] RD_OP    = 2'b10;

endpackage

// File: rtl/mdio_rd_mdcgen.sv
module mdio_rd_mdcgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_p,
  output logic fall_p
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc    = mdc_q;
  assign rise_p = run & wrap & ~mdc_q;
  assign fall_p = run & wrap &  mdc_q;

  // R9
  rise_sets_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> mdc);
  // R9
  fall_clears_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_p |=> !mdc);

endmodule

// File: rtl/mdio_rd_fsm.sv
module mdio_rd_fsm
  import mdio_rd_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_phy,
  input  logic [AW-1:0] cmd_reg,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic          mdio_i,
  output logic          busy,
  output logic          accept,
  output logic          done,
  output logic [DW-1:0] rx_data,
  output logic          mdio_o,
  output logic          mdio_oe
);

  localparam int HDR_W = 4 + 2 * AW;
  localparam int MAXL  = (PRE_LEN > HDR_W) ? ((PRE_LEN > DW) ? PRE_LEN : DW)
                                           : ((HDR_W > DW) ? HDR_W : DW);
  localparam int CNT_W = $clog2(MAXL + 1);

  mrd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HDR_W-1:0] tx_q, tx_d;
  logic [DW-1:0]    rx_q, rx_d;
  logic             mdo_q, mdo_d;
  logic             oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    mdo_d   = mdo_q;
    oe_d    = oe_q;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          state_d = ST_PRE;
          cnt_d   = '0;
          tx_d    = {SOF_BITS, RD_OP, cmd_phy, cmd_reg};
          mdo_d   = 1'b1;
          oe_d    = 1'b1;
        end
      end
      ST_PRE: begin
        if (fall_p) begin
          if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
            state_d = ST_HDR;
            cnt_d   = '0;
            mdo_d   = tx_q[HDR_W-1];
            tx_d    = {tx_q[HDR_W-2:0], 1'b0};
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_HDR: begin
        if (fall_p) begin
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            state_d = ST_TA;
            cnt_d   = '0;
            mdo_d   = 1'b0;
            oe_d    = 1'b0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
            mdo_d = tx_q[HDR_W-1];
            tx_d  = {tx_q[HDR_W-2:0], 1'b0};
          end
        end
      end
      ST_TA: begin
        // the PHY's leading bit arrives in the second period and is not sampled
        if (fall_p) begin
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (rise_p) rx_d = {rx_q[DW-2:0], mdio_i};
        if (fall_p) begin
          if (cnt_q == CNT_W'(DW - 1)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done    = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      mdo_q   <= mdo_d;
      oe_q    <= oe_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign accept  = cmd_wr & (state_q == ST_IDLE);
  assign rx_data = rx_q;
  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;

  // R4
  pad_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_p || accept) |=> ($stable(mdio_o) && $stable(mdio_oe)));
  // R4
  released_in_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TA || state_q == ST_DATA) |-> !mdio_oe);
  // R2
  driven_in_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> (mdio_oe && mdio_o));

endmodule

// File: rtl/mdio_rd_cmdreg.sv
module mdio_rd_cmdreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_ie,
  input  logic          busy,
  input  logic          accept,
  input  logic          done,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          irq
);

  logic          ie_q, ie_d;
  logic          rdy_q, rdy_d;
  logic          irq_q, irq_d;
  logic [DW-1:0] data_q;
  logic          data_en;

  assign data_en = done;

  always_comb begin
    ie_d  = ie_q;
    rdy_d = rdy_q;
    irq_d = irq_q;
    if (accept) begin
      ie_d  = cmd_ie;
      rdy_d = 1'b0;
      irq_d = 1'b0;
    end else if (done) begin
      rdy_d = 1'b1;
      irq_d = ie_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      rdy_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      rdy_q <= rdy_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= rx_data;
    end
  end

  assign rd_data = data_q;
  assign rdy     = rdy_q;
  assign irq     = irq_q;

  // R6
  rdy_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy);
  // R7
  irq_implies_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdy);
  // R8
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ($stable(ie_q) && !$rose(rdy)));

endmodule

// File: rtl/mdio_rd_master.sv
module mdio_rd_master #(
  parameter int HALF_DIV = 4,
  parameter int PRE_LEN  = 32,
  parameter int AW       = 5,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_phy,
  input  logic [AW-1:0] cmd_reg,
  input  logic          cmd_ie,
  output logic          busy,
  output logic          rdy,
  output logic          irq,
  output logic [DW-1:0] rd_data,
  output logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          rise_p, fall_p;
  logic          accept, done;
  logic [DW-1:0] rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mdio_rd_mdcgen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (busy),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_rd_fsm #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmd_wr  (cmd_wr),
    .cmd_phy (cmd_phy),
    .cmd_reg (cmd_reg),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .accept  (accept),
    .done    (done),
    .rx_data (rx_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_rd_cmdreg #(.DW(DW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cmd_wr  (cmd_wr),
    .cmd_ie  (cmd_ie),
    .busy    (busy),
    .accept  (accept),
    .done    (done),
    .rx_data (rx_data),
    .rd_data (rd_data),
    .rdy     (rdy),
    .irq     (irq)
  );

  // R9
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !mdc);
  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !busy);

endmodule

// File: tb/sim_mdio_rd_master.sv
module sim_mdio_rd_master;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic        cmd_ie = 1'b0;
  logic        busy, rdy, irq, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] phy_data = '0;
  logic        lead_bit = 1'b0;

  int          cyc = 0;
  int          ridx = 0;
  int          last_rise = -1;
  int          per_bad = 0;
  logic        busy_prev = 1'b0;
  logic        mdc_prev = 1'b0;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;

  always #5 clk = ~clk;

  mdio_rd_master #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_ie(cmd_ie), .busy(busy), .rdy(rdy), .irq(irq),
    .rd_data(rd_data), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );

  function automatic logic reply(input int k);
    if (k == 47) return lead_bit;
    if (k >= 48 && k <= 63) return phy_data[63-k];
    return 1'b1;
  endfunction

  // PHY model and frame monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy && !busy_prev) begin
      ridx = 0; last_rise = -1; per_bad = 0;
    end
    if (mdc && !mdc_prev) begin
      if (ridx < 64) begin
        cap_o[ridx]  = mdio_o;
        cap_oe[ridx] = mdio_oe;
      end
      if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) per_bad = per_bad + 1;
      last_rise = cyc;
      ridx = ridx + 1;
    end
    if (!mdc && mdc_prev) mdio_i = reply(ridx);
    busy_prev = busy;
    mdc_prev  = mdc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [4:0] p, input logic [4:0] r, input logic ie,
                         input logic [15:0] d, input logic lb, input bit inject);
    int wait_c;
    logic [13:0] hdr;
    phy_data = d;
    lead_bit = lb;
    @(negedge clk);
    cmd_phy = p; cmd_reg = r; cmd_ie = ie; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    chk(rdy == 1'b0, "R8 rdy cleared", int'(rdy), 0);
    chk(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
    if (inject) begin
      repeat (135) @(negedge clk);
      cmd_phy = ~p; cmd_reg = ~r; cmd_ie = ~ie; cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
    end
    wait_c = 0;
    while (busy && wait_c < 2000) begin
      @(negedge clk);
      wait_c = wait_c + 1;
    end
    chk(!busy, "R6 read completes", wait_c, 0);
    chk(rdy == 1'b1, "R6 rdy at completion", int'(rdy), 1);
    chk(ridx == 64, "R6 rising edge count", ridx, 64);
    chk(rd_data == d, "R5 data", int'(rd_data), int'(d));
    chk(irq == ie, "R7 irq follows enable", int'(irq), int'(ie));
    chk(!mdc && !mdio_oe, "R9 idle pins", int'({mdc, mdio_oe}), 0);
    chk(per_bad == 0, "R9 MDC period", per_bad, 0);
    chk(&cap_o[31:0] && &cap_oe[31:0], "R2 preamble",
        int'(cap_o[31:0] & cap_oe[31:0]), 32'hFFFF_FFFF);
    hdr = {2'b01, 2'b10, p, r};
    for (int k = 0; k < 14; k++)
      chk(cap_o[32+k] == hdr[13-k] && cap_oe[32+k], "R3 header bit",
          int'({cap_oe[32+k], cap_o[32+k]}), int'({1'b1, hdr[13-k]}));
    chk(cap_oe[63:46] == '0, "R4 released", int'(cap_oe[63:46]), 0);
    if (inject) begin
      repeat (12) @(negedge clk);
      chk(!busy && rdy, "R8 ignored cmd starts nothing", int'({busy, rdy}), 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk({rdy, irq, busy, mdc, mdio_oe} == 5'b0, "R1 in reset",
        int'({rdy, irq, busy, mdc, mdio_oe}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({rdy, irq, busy, mdc, mdio_oe} == 5'b0, "R1 after reset",
        int'({rdy, irq, busy, mdc, mdio_oe}), 0);
    // R10 sweep of PHY addresses
    for (int p = 0; p < 32; p++)
      run_txn(5'(p), 5'((p * 7 + 3) % 32), p[0],
              16'((p * 16'h3A5B) ^ (p << 9) ^ 16'h00C3), p[1], 1'b0);
    // R10 sweep of register addresses
    for (int r = 0; r < 32; r++)
      run_txn(5'((r * 11 + 5) % 32), 5'(r), ~r[0],
              16'((r * 16'h1F07) ^ 16'hA55A), ~r[2], 1'b0);
    // data extremes, lead bit opposite to data
    run_txn(5'd0, 5'd31, 1'b1, 16'h0000, 1'b1, 1'b0);
    run_txn(5'd31, 5'd0, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    // R8 command during the header phase is dropped
    run_txn(5'b10110, 5'b01001, 1'b0, 16'h8001, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule